// File: doc/BRIEF.md
# Pin Bank with Event Detection

A bank of general-purpose pins, 32 by default, controlled through a word-addressed register port. The port has an address, write data, a write strobe and registered read data. Each pin can drive an output or be sampled as an input. Every input passes through a synchroniser. Four independently armed detectors watch each pin: level low, level high, rising edge and falling edge.

Detected events collect in a status word. Software clears that word by writing ones. Status bits that software has enabled are OR-ed into a single interrupt line. A second output, the wake request, pulses when an event lands on a pin selected for wake-up.

Software can set or clear output bits and interrupt-enable bits in one write, with no read-modify-write. A control bit freezes the whole detection path to model the module being switched off.

Top module: `pinbank_irq`

## Requirements
- R1: After reset every pin is an input: the direction word (address 0x2, bit set = input) reads all ones and `pin_oe_o` is all zeros. The output word, the status word (0xB) and both `irq_o` and `wake_o` are zero.
- R2: `pin_oe_o[i]` is the inverse of direction bit i, and `pin_out_o` presents the output word (address 0x4).
- R3: A write to address 0x5 sets the output bits written as 1, and a write to 0x6 clears them. Bits written as 0 keep their value. Address 0x4 can be written and read back directly.
- R4: Address 0x3 returns the pin inputs after a two-stage synchroniser. Reading it changes nothing.
- R5: The rising-edge enables (0x9) and falling-edge enables (0xA) are separate bits, so a pin armed in both reports an event on each transition.
- R6: The level-high enables (0x8) and level-low enables (0x7) set the status bit on every cycle the level holds. A status bit cleared while the level persists reads back as set, and it stays clear once the level has gone away.
- R7: Writing a mask to the status word (0xB) clears only the bits written as 1. An event arriving in the same cycle as the clear of its bit leaves that bit set.
- R8: The interrupt-enable word (0xC) also has a set alias (0xD) and a clear alias (0xE) that take a mask. `irq_o` is asserted, one cycle after the status changes, exactly when some status bit and its enable are both 1.
- R9: `wake_o` pulses for one cycle, three clocks after an input edge, when the pin has an event and its bit in the wake-enable word (0xF) is 1. An event on a pin not enabled for wake never asserts it.
- R10: While bit 0 of the control word (0x1) is 1, the synchroniser and detectors are frozen and no status bit becomes set. Writing 0 resumes operation.
- R11: Address 0x0 reads the revision: major number in bits 7:4, minor number in bits 3:0 (defaults 2 and 1, giving 0x21), and zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 4 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid one cycle after the address |
| pin_in_i | input | NPINS | Asynchronous pin inputs |
| pin_out_o | output | NPINS | Pin output values |
| pin_oe_o | output | NPINS | Pin output enables, 1 drives |
| irq_o | output | 1 | Bank interrupt |
| wake_o | output | 1 | Wake request pulse |

## Verification
The bench aims each test at a point where a plausible mistake produces a visible difference.

- **Level re-assertion.** The bench clears a status bit while its level is still present. A design that latched level events once would read back 0 here.
- **Edge arming.** The bench arms both edges on one pin. A design with a single polarity select would miss one transition.
- **Clear versus event collision.** The bench times a status clear to coincide with a fresh edge on the same bit. A design that gives the clear priority loses the event.
- **Atomic set and clear.** Masked writes to the output and enable aliases catch a design that overwrites the whole word.
- **Negative checks.** The bench watches `wake_o` during events on a pin not enabled for wake, and reads status while the module is gated. Together these catch missing gating.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    RG_REV      = 4'h0,
    RG_CTRL     = 4'h1,
    RG_DIR      = 4'h2,
    RG_DIN      = 4'h3,
    RG_DOUT     = 4'h4,
    RG_DOUT_SET = 4'h5,
    RG_DOUT_CLR = 4'h6,
    RG_DET_LO   = 4'h7,
    RG_DET_HI   = 4'h8,
    RG_DET_RISE = 4'h9,
    RG_DET_FALL = 4'hA,
    RG_STAT     = 4'hB,
    RG_IEN      = 4'hC,
    RG_IEN_SET  = 4'hD,
    RG_IEN_CLR  = 4'hE,
    RG_WAKE     = 4'hF
  } reg_sel_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_dly_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      q_dly_o <= '0;
    end else if (en_i) begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      q_dly_o <= stg[STAGES-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pinbank_detect.sv
module pinbank_detect #(
  parameter int WIDTH = 32
) (
  input  logic             run_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] en_lo_i,
  input  logic [WIDTH-1:0] en_hi_i,
  input  logic [WIDTH-1:0] en_rise_i,
  input  logic [WIDTH-1:0] en_fall_i,
  output logic [WIDTH-1:0] ev_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic lvl_lo, lvl_hi, edg_up, edg_dn;
    assign lvl_lo = en_lo_i[i]   & ~cur_i[i];
    assign lvl_hi = en_hi_i[i]   &  cur_i[i];
    assign edg_up = en_rise_i[i] &  cur_i[i] & ~prev_i[i];
    assign edg_dn = en_fall_i[i] & ~cur_i[i] &  prev_i[i];
    assign ev_o[i] = run_i & (lvl_lo | lvl_hi | edg_up | edg_dn);
  end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter int SYNC_DEPTH = 2,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [BUS_W-1:0]  rd_data_o,
  input  logic [NPINS-1:0]  pin_in_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam logic [7:0] REV_WORD = {4'(REV_MAJOR), 4'(REV_MINOR)};

  logic             gate_q;
  logic [NPINS-1:0] dir_q, dout_q, lo_q, hi_q, rise_q, fall_q;
  logic [NPINS-1:0] stat_q, ien_q, wake_en_q;
  logic [NPINS-1:0] pin_s, pin_d, ev;
  logic [NPINS-1:0] wd, stat_clr;
  logic             run;
  logic [BUS_W-1:0] rd_mux;

  assign run = ~gate_q;
  assign wd  = wr_data_i[NPINS-1:0];
  assign stat_clr = (wr_en_i && addr_i == RG_STAT) ? wd : '0;

  pinbank_sync #(.WIDTH(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (run),
    .d_i     (pin_in_i),
    .q_o     (pin_s),
    .q_dly_o (pin_d)
  );

  pinbank_detect #(.WIDTH(NPINS)) u_det (
    .run_i     (run),
    .cur_i     (pin_s),
    .prev_i    (pin_d),
    .en_lo_i   (lo_q),
    .en_hi_i   (hi_q),
    .en_rise_i (rise_q),
    .en_fall_i (fall_q),
    .ev_o      (ev)
  );

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      RG_REV:      rd_mux = BUS_W'(REV_WORD);
      RG_CTRL:     rd_mux = BUS_W'(gate_q);
      RG_DIR:      rd_mux = BUS_W'(dir_q);
      RG_DIN:      rd_mux = BUS_W'(pin_s);
      RG_DOUT:     rd_mux = BUS_W'(dout_q);
      RG_DET_LO:   rd_mux = BUS_W'(lo_q);
      RG_DET_HI:   rd_mux = BUS_W'(hi_q);
      RG_DET_RISE: rd_mux = BUS_W'(rise_q);
      RG_DET_FALL: rd_mux = BUS_W'(fall_q);
      RG_STAT:     rd_mux = BUS_W'(stat_q);
      RG_IEN:      rd_mux = BUS_W'(ien_q);
      RG_WAKE:     rd_mux = BUS_W'(wake_en_q);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gate_q    <= 1'b0;
      dir_q     <= '1;
      dout_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      rise_q    <= '0;
      fall_q    <= '0;
      stat_q    <= '0;
      ien_q     <= '0;
      wake_en_q <= '0;
      irq_o     <= 1'b0;
      wake_o    <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (wr_en_i) begin
        case (addr_i)
          RG_CTRL:     gate_q    <= wr_data_i[0];
          RG_DIR:      dir_q     <= wd;
          RG_DOUT:     dout_q    <= wd;
          RG_DOUT_SET: dout_q    <= dout_q | wd;
          RG_DOUT_CLR: dout_q    <= dout_q & ~wd;
          RG_DET_LO:   lo_q      <= wd;
          RG_DET_HI:   hi_q      <= wd;
          RG_DET_RISE: rise_q    <= wd;
          RG_DET_FALL: fall_q    <= wd;
          RG_IEN:      ien_q     <= wd;
          RG_IEN_SET:  ien_q     <= ien_q | wd;
          RG_IEN_CLR:  ien_q     <= ien_q & ~wd;
          RG_WAKE:     wake_en_q <= wd;
          default: ;
        endcase
      end
      // a fresh event outranks a same-cycle clear
      stat_q    <= (stat_q & ~stat_clr) | ev;
      irq_o     <= |(stat_q & ien_q);
      wake_o    <= |(ev & wake_en_q);
      rd_data_o <= rd_mux;
    end
  end

  assign pin_out_o = dout_q;
  assign pin_oe_o  = ~dir_q;
endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk
  import pinbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              gate_q,
  input logic [NPINS-1:0]  ev,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  wake_en_q,
  input logic [NPINS-1:0]  stat_clr,
  input logic [NPINS-1:0]  dout_q,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wd,
  input logic              irq_o,
  input logic              wake_o
);
  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (stat_clr != '0) |=> ((stat_q & $past(stat_clr) & ~$past(ev)) == '0));

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> $past((stat_q & ien_q) != '0));

  assert_wake_src_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_o |-> $past((ev & wake_en_q) != '0));

  assert_gate_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    gate_q |=> ((stat_q & ~$past(stat_q)) == '0));

  assert_dout_set_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == RG_DOUT_SET) |=> ((dout_q & $past(wd)) == $past(wd)));
endmodule

bind pinbank_irq pinbank_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .gate_q    (gate_q),
  .ev        (ev),
  .stat_q    (stat_q),
  .ien_q     (ien_q),
  .wake_en_q (wake_en_q),
  .stat_clr  (stat_clr),
  .dout_q    (dout_q),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wd        (wd),
  .irq_o     (irq_o),
  .wake_o    (wake_o)
);

// File: tb/pinbank_irq_tb.sv
module pinbank_irq_tb;
  import pinbank_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq, wake;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] r;

  always #10 clk = ~clk;

  pinbank_irq u_dut (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .pin_in_i(pin_in),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(reg_sel_e a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(reg_sel_e a, output logic [31:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset;
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq/wake", {30'd0, irq, wake}, 32'h0);
    rd(RG_DIR, r);  chk("R1 dir", r, 32'hFFFF_FFFF);
    rd(RG_STAT, r); chk("R1 stat", r, 32'h0);
  endtask

  task automatic t_rev;
    rd(RG_REV, r); chk("R11 revision", r, 32'h0000_0021);
  endtask

  task automatic t_dir_dout;
    wr(RG_DIR, 32'hFFFF_0000);
    chk("R2 oe", pin_oe, 32'h0000_FFFF);
    wr(RG_DOUT, 32'h1234_5678);
    chk("R2 pin_out", pin_out, 32'h1234_5678);
    wr(RG_DOUT_SET, 32'h0000_000F);
    chk("R3 set", pin_out, 32'h1234_567F);
    wr(RG_DOUT_CLR, 32'h1200_0000);
    chk("R3 clr", pin_out, 32'h0034_567F);
    rd(RG_DOUT, r); chk("R3 readback", r, 32'h0034_567F);
    wr(RG_DIR, 32'hFFFF_FFFF);
  endtask

  task automatic t_datain;
    pin_in = 32'hA5A5_0000;
    idle(3);
    rd(RG_DIN, r); chk("R4 din", r, 32'hA5A5_0000);
    rd(RG_DIN, r); chk("R4 din repeat", r, 32'hA5A5_0000);
    rd(RG_STAT, r); chk("R4 no side effect", r, 32'h0);
    pin_in = '0;
    idle(4);
  endtask

  task automatic t_edges;
    wr(RG_DET_RISE, 32'h5);
    wr(RG_DET_FALL, 32'h6);
    pin_in[2:0] = 3'b111;
    idle(5);
    rd(RG_STAT, r); chk("R5 rising", r, 32'h5);
    wr(RG_STAT, 32'hFFFF_FFFF);
    pin_in[2:0] = 3'b000;
    idle(5);
    rd(RG_STAT, r); chk("R5 falling both-armed", r, 32'h6);
    wr(RG_DET_RISE, 0); wr(RG_DET_FALL, 0);
    wr(RG_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    wr(RG_DET_HI, 32'h10);
    pin_in[4] = 1'b1;
    idle(5);
    wr(RG_STAT, 32'hFFFF_FFFF);
    rd(RG_STAT, r); chk("R6 level persists", r, 32'h10);
    pin_in[4] = 1'b0;
    idle(5);
    wr(RG_STAT, 32'hFFFF_FFFF);
    rd(RG_STAT, r); chk("R6 level removed", r, 32'h0);
    wr(RG_DET_HI, 0);
    wr(RG_DET_LO, 32'h20);
    idle(3);
    rd(RG_STAT, r); chk("R6 level low", r, 32'h20);
    wr(RG_DET_LO, 0);
    wr(RG_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide;
    wr(RG_DET_RISE, 32'h400);
    pin_in[10] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr(RG_STAT, 32'h400);
    rd(RG_STAT, r); chk("R7 set wins", r, 32'h400);
    wr(RG_STAT, 32'h400);
    rd(RG_STAT, r); chk("R7 cleared", r, 32'h0);
  endtask

  task automatic t_w1c;
    wr(RG_DET_RISE, 32'h300);
    pin_in[9:8] = 2'b11;
    idle(5);
    wr(RG_STAT, 32'h100);
    rd(RG_STAT, r); chk("R7 mask only", r, 32'h200);
  endtask

  task automatic t_irq;
    chk("R8 irq off", {31'd0, irq}, 32'h0);
    wr(RG_IEN_SET, 32'h300);
    idle(1);
    chk("R8 irq on", {31'd0, irq}, 32'h1);
    rd(RG_IEN, r); chk("R8 ien set", r, 32'h300);
    wr(RG_IEN_CLR, 32'h200);
    idle(1);
    chk("R8 irq after clr", {31'd0, irq}, 32'h0);
    rd(RG_IEN, r); chk("R8 ien clr", r, 32'h100);
    wr(RG_IEN, 32'h0);
    wr(RG_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_wake;
    wr(RG_DET_RISE, 32'h3000);
    wr(RG_WAKE, 32'h1000);
    pin_in[13] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R9 no wake", {31'd0, wake}, 32'h0);
    end
    pin_in[12] = 1'b1;
    idle(3);
    chk("R9 wake pulse", {31'd0, wake}, 32'h1);
    idle(1);
    chk("R9 wake ends", {31'd0, wake}, 32'h0);
    wr(RG_WAKE, 0); wr(RG_DET_RISE, 0);
    wr(RG_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_gate;
    wr(RG_CTRL, 32'h1);
    rd(RG_CTRL, r); chk("R10 ctrl", r, 32'h1);
    wr(RG_DET_RISE, 32'h1_0000);
    wr(RG_DET_HI, 32'h2_0000);
    pin_in[17:16] = 2'b11;
    idle(6);
    rd(RG_STAT, r); chk("R10 gated", r, 32'h0);
    wr(RG_DET_RISE, 0); wr(RG_DET_HI, 0);
    wr(RG_CTRL, 32'h0);
    rd(RG_CTRL, r); chk("R10 ungated", r, 32'h0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_rev();
    t_dir_dout();
    t_datain();
    t_edges();
    t_level();
    t_collide();
    t_w1c();
    t_irq();
    t_wake();
    t_gate();
    finish_run();
  end
endmodule